// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

The block gathers sixteen interrupt request lines into one interrupt request for a processor. Two eight-line priority controllers are joined. The first, the master, owns lines 0 to 7 and talks to the processor. The second, the slave, owns lines 8 to 15. The slave's arbitration result takes the place of master line 2. Each controller latches rising edges into a request register. It filters them through its mask register and arbitrates cyclically from a programmable top-priority line. Any line currently being serviced blocks arbitration at its own priority and below.

The processor raises a one-clock acknowledge when it takes the interrupt. The block then moves the winning request into service and returns an 8-bit vector on the following cycle. Through line 2 this reaches the slave's winner. When nothing is pending at acknowledge, the block returns a spurious vector that points at line 7 of the controller concerned. A master line 2 request left behind by a slave that has since lost its request is dropped, so that lower master lines still get through. A small write port programs masks, vector bases and rotation offsets, and issues end-of-interrupt commands.

Top module: `cascade_intc`

## Requirements
- R1: After reset, int_o is 0, vec_o is 0, every request and in-service bit is clear, every mask bit is set (masked), both vector bases are 0 and both rotation offsets are 0.
- R2: A request bit is set only by a 0-to-1 change on its input line, sampled on the clock. A level held high after acknowledge raises no new request.
- R3: int_o is 1 exactly when the master has a winning request, and follows each change of request, mask or in-service state.
- R4: A controller scans its lines starting at its offset and wraps from 7 to 0. The first line whose in-service bit is set ends the scan with no winner. Otherwise the first unmasked pending line wins.
- R5: When ack_i is 1 and the master winner is not line 2, the request bit of that line is cleared and its in-service bit is set. In the next cycle vec_o = master base + line, and vec_o holds until the next acknowledge.
- R6: A slave winner raises master line 2 on the cycle after it appears, as an edge. Acknowledging master line 2 also moves the slave winner into service and gives vec_o = slave base + slave line.
- R7: Acknowledge with no master winner gives vec_o = master base + 7 and changes no state.
- R8: Acknowledge of master line 2 while the slave has no winner gives vec_o = slave base + 7 and leaves all slave state unchanged.
- R9: While master line 2 wins but the slave has no winner, master request bit 2 is cleared on the next clock, so that lower-priority master lines win.
- R10: An end-of-interrupt command clears only the highest-priority set in-service bit, counted from the offset, of the controller it addresses.
- R11: Input line irq_i[2] has no effect. Master line 2 is driven only by the slave.
- R12: A write with wr_en_i = 1 uses wr_addr_i[2] to pick the controller (0 master, 1 slave). wr_addr_i[1:0] picks the action: 0 loads the mask (bit = 1 masks the line), 1 loads the vector base, 2 loads the offset from wr_data_i[2:0], 3 issues end-of-interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 16 | Request lines; [7:0] master, [15:8] slave |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 3 | Controller select and action |
| wr_data_i | input | 8 | Write data |
| ack_i | input | 1 | Interrupt acknowledge, one clock wide |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector of the last acknowledge |

## Verification
Pairs of simultaneous master requests separate fixed priority from rotated priority, and a nested acknowledge separates in-service blocking from plain masking. Slave requests taken straight through show the cascade path. Slave requests masked after they reached master line 2 separate the slave-spurious vector from the cleanup of the stale line 2. One variant runs with a lower master line pending and one without, to tell re-arbitration apart from a dropped int_o. Held levels, a pulse on irq_i[2] and end-of-interrupt sent to the wrong controller show what must have no effect. A cycle-by-cycle model checks int_o and vec_o throughout.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    FN_MASK = 2'd0,
    FN_BASE = 2'd1,
    FN_OFS  = 2'd2,
    FN_EOI  = 2'd3
  } intc_fn_e;
endpackage

// File: rtl/intc_prio.sv
// Cyclic priority scan; a set block bit ends the scan with no winner.
module intc_prio #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = $clog2(N)
) (
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  blk_i,
  input  logic [LW-1:0] ofs_i,
  output logic          vld_o,
  output logic [LW-1:0] line_o
);
  always_comb begin
    logic          stop;
    logic [LW-1:0] idx;
    vld_o  = 1'b0;
    line_o = '0;
    stop   = 1'b0;
    for (int k = 0; k < int'(N); k++) begin
      idx = ofs_i + LW'(k);
      if (!stop) begin
        if (blk_i[idx]) begin
          stop = 1'b1;
        end else if (pend_i[idx]) begin
          vld_o  = 1'b1;
          line_o = idx;
          stop   = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/intc_unit.sv
module intc_unit #(
  parameter int unsigned N  = 8,
  parameter int unsigned DW = 8,
  parameter int unsigned LW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  clr_i,
  input  logic          ack_i,
  input  logic          mask_we_i,
  input  logic          base_we_i,
  input  logic          ofs_we_i,
  input  logic          eoi_i,
  input  logic [DW-1:0] wdata_i,
  output logic          win_vld_o,
  output logic [LW-1:0] win_line_o,
  output logic [DW-1:0] base_o
);
  logic [N-1:0]  req_q, irr_q, imr_q, isr_q;
  logic [N-1:0]  irr_d, isr_d;
  logic [LW-1:0] ofs_q;
  logic [DW-1:0] base_q;
  logic          eoi_vld;
  logic [LW-1:0] eoi_line;

  intc_prio #(.N(N), .LW(LW)) u_win (
    .pend_i (irr_q & ~imr_q),
    .blk_i  (isr_q),
    .ofs_i  (ofs_q),
    .vld_o  (win_vld_o),
    .line_o (win_line_o)
  );

  // highest-priority in-service bit, for end of interrupt
  intc_prio #(.N(N), .LW(LW)) u_eoi (
    .pend_i (isr_q),
    .blk_i  ('0),
    .ofs_i  (ofs_q),
    .vld_o  (eoi_vld),
    .line_o (eoi_line)
  );

  for (genvar i = 0; i < N; i++) begin : g_line
    logic rise, ack_hit, eoi_hit;
    assign rise    = req_i[i] & ~req_q[i];
    assign ack_hit = ack_i & win_vld_o & (win_line_o == LW'(i));
    assign eoi_hit = eoi_i & eoi_vld & (eoi_line == LW'(i));
    // new edge wins over clear; acknowledge wins over end of interrupt
    assign irr_d[i] = rise | (irr_q[i] & ~ack_hit & ~clr_i[i]);
    assign isr_d[i] = ack_hit | (isr_q[i] & ~eoi_hit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      irr_q  <= '0;
      isr_q  <= '0;
      imr_q  <= '1;
      ofs_q  <= '0;
      base_q <= '0;
    end else begin
      req_q <= req_i;
      irr_q <= irr_d;
      isr_q <= isr_d;
      if (mask_we_i) imr_q  <= wdata_i[N-1:0];
      if (ofs_we_i)  ofs_q  <= wdata_i[LW-1:0];
      if (base_we_i) base_q <= wdata_i;
    end
  end

  assign base_o = base_q;
endmodule

// File: rtl/cascade_intc.sv
module cascade_intc #(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned CASC    = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [2*N_LINES-1:0]   irq_i,
  input  logic                   wr_en_i,
  input  logic [2:0]             wr_addr_i,
  input  logic [VEC_W-1:0]       wr_data_i,
  input  logic                   ack_i,
  output logic                   int_o,
  output logic [VEC_W-1:0]       vec_o
);
  import intc_pkg::*;

  localparam int unsigned LW = $clog2(N_LINES);
  localparam int unsigned SPUR = N_LINES - 1;
  localparam logic [N_LINES-1:0] CASC_BIT = N_LINES'(1) << CASC;

  logic                m_vld, s_vld;
  logic [LW-1:0]       m_line, s_line;
  logic [VEC_W-1:0]    m_base, s_base;
  logic [N_LINES-1:0]  m_req, s_req, m_clr;
  logic                s_ack, m_on_casc;
  intc_fn_e            fn;
  logic [VEC_W-1:0]    vec_d, vec_q;

  logic               vld_v  [2];
  logic [LW-1:0]      line_v [2];
  logic [VEC_W-1:0]   base_v [2];

  assign fn        = intc_fn_e'(wr_addr_i[1:0]);
  assign m_on_casc = m_vld & (m_line == LW'(CASC));

  // external line at the cascade position is replaced by the slave result
  assign m_req = (irq_i[N_LINES-1:0] & ~CASC_BIT) | (s_vld ? CASC_BIT : '0);
  assign s_req = irq_i[2*N_LINES-1:N_LINES];
  assign m_clr = (m_on_casc & ~s_vld) ? CASC_BIT : '0;
  assign s_ack = ack_i & m_on_casc;

  for (genvar g = 0; g < 2; g++) begin : g_ctl
    logic hit;
    assign hit = wr_en_i & (wr_addr_i[2] == 1'(g));
    intc_unit #(.N(N_LINES), .DW(VEC_W), .LW(LW)) u_ctl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (g == 0 ? m_req : s_req),
      .clr_i      (g == 0 ? m_clr : '0),
      .ack_i      (g == 0 ? ack_i : s_ack),
      .mask_we_i  (hit & (fn == FN_MASK)),
      .base_we_i  (hit & (fn == FN_BASE)),
      .ofs_we_i   (hit & (fn == FN_OFS)),
      .eoi_i      (hit & (fn == FN_EOI)),
      .wdata_i    (wr_data_i),
      .win_vld_o  (vld_v[g]),
      .win_line_o (line_v[g]),
      .base_o     (base_v[g])
    );
  end

  assign m_vld  = vld_v[0];
  assign s_vld  = vld_v[1];
  assign m_line = line_v[0];
  assign s_line = line_v[1];
  assign m_base = base_v[0];
  assign s_base = base_v[1];

  always_comb begin
    if (!m_vld)         vec_d = m_base + VEC_W'(SPUR);
    else if (!m_on_casc) vec_d = m_base + VEC_W'(m_line);
    else if (s_vld)     vec_d = s_base + VEC_W'(s_line);
    else                vec_d = s_base + VEC_W'(SPUR);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    vec_q <= '0;
    else if (ack_i) vec_q <= vec_d;
  end

  assign int_o = m_vld;
  assign vec_o = vec_q;
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int unsigned LW   = 3,
  parameter int unsigned VW   = 8,
  parameter int unsigned CASC = 2,
  parameter int unsigned SPUR = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ack_i,
  input logic [VW-1:0] vec_o,
  input logic          m_vld,
  input logic          s_vld,
  input logic [LW-1:0] m_line,
  input logic [LW-1:0] s_line,
  input logic [VW-1:0] m_base,
  input logic [VW-1:0] s_base
);
  // R5
  vec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> $stable(vec_o));

  // R5
  vec_master_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && m_vld && m_line != LW'(CASC)) |=>
      vec_o == VW'($past(m_base) + VW'($past(m_line))));

  // R6
  vec_slave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && m_vld && m_line == LW'(CASC) && s_vld) |=>
      vec_o == VW'($past(s_base) + VW'($past(s_line))));

  // R7
  spur_master_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !m_vld) |=> vec_o == VW'($past(m_base) + VW'(SPUR)));

  // R8
  spur_slave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && m_vld && m_line == LW'(CASC) && !s_vld) |=>
      vec_o == VW'($past(s_base) + VW'(SPUR)));

  // R9
  stale_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_vld && m_line == LW'(CASC) && !s_vld) |=>
      !(m_vld && m_line == LW'(CASC)));
endmodule

bind cascade_intc intc_chk #(.LW(LW), .VW(VEC_W), .CASC(CASC), .SPUR(SPUR)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ack_i  (ack_i),
  .vec_o  (vec_o),
  .m_vld  (m_vld),
  .s_vld  (s_vld),
  .m_line (m_line),
  .s_line (s_line),
  .m_base (m_base),
  .s_base (s_base)
);

// File: tb/sim_cascade_intc.sv
`timescale 1ns/1ps
module sim_cascade_intc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] irq_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic        ack_i = 1'b0;
  logic        int_o;
  logic [7:0]  vec_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  cascade_intc u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .ack_i(ack_i),
    .int_o(int_o), .vec_o(vec_o)
  );

  // reference model
  bit [7:0] e_irr[2], e_imr[2], e_isr[2], e_rq[2], e_base[2];
  int       e_ofs[2];
  bit [7:0] e_vec;

  function automatic int pick(int c);
    for (int k = 0; k < 8; k++) begin
      int idx = (e_ofs[c] + k) % 8;
      if (e_isr[c][idx]) return -1;
      if (e_irr[c][idx] && !e_imr[c][idx]) return idx;
    end
    return -1;
  endfunction

  function automatic int top_isr(int c);
    for (int k = 0; k < 8; k++) begin
      int idx = (e_ofs[c] + k) % 8;
      if (e_isr[c][idx]) return idx;
    end
    return -1;
  endfunction

  task automatic step();
    int sw, mw, t[2];
    bit [7:0] in_v[2];
    sw = pick(1);
    mw = pick(0);
    t[0] = top_isr(0);
    t[1] = top_isr(1);
    in_v[0] = irq_i[7:0];
    in_v[0][2] = (sw >= 0);
    in_v[1] = irq_i[15:8];
    if (wr_en_i && wr_addr_i[1:0] == 2'd3 && t[wr_addr_i[2]] >= 0)
      e_isr[wr_addr_i[2]][t[wr_addr_i[2]]] = 1'b0;
    if (ack_i) begin
      if (mw < 0) e_vec = e_base[0] + 8'd7;
      else begin
        e_irr[0][mw] = 1'b0;
        e_isr[0][mw] = 1'b1;
        if (mw != 2) e_vec = e_base[0] + 8'(mw);
        else if (sw >= 0) begin
          e_irr[1][sw] = 1'b0;
          e_isr[1][sw] = 1'b1;
          e_vec = e_base[1] + 8'(sw);
        end else e_vec = e_base[1] + 8'd7;
      end
    end
    if (mw == 2 && sw < 0) e_irr[0][2] = 1'b0;
    for (int c = 0; c < 2; c++) begin
      e_irr[c] = e_irr[c] | (in_v[c] & ~e_rq[c]);
      e_rq[c] = in_v[c];
    end
    if (wr_en_i) begin
      case (wr_addr_i[1:0])
        2'd0: e_imr[wr_addr_i[2]] = wr_data_i;
        2'd1: e_base[wr_addr_i[2]] = wr_data_i;
        2'd2: e_ofs[wr_addr_i[2]] = int'(wr_data_i[2:0]);
        default: ;
      endcase
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < 2; c++) begin
        e_irr[c] = '0; e_isr[c] = '0; e_imr[c] = '1; e_rq[c] = '0;
        e_base[c] = '0; e_ofs[c] = 0;
      end
      e_vec = '0;
    end else step();
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R3 model int_o", int'(int_o), int'(pick(0) >= 0));
      chk("R5 model vec_o", int'(vec_o), int'(e_vec));
    end
  end

  task automatic tick(); @(negedge clk_i); endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic pulse(logic [15:0] lines);
    irq_i = lines;
    tick();
    irq_i = '0;
  endtask

  task automatic ack();
    ack_i = 1'b1;
    tick();
    ack_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    chk("R1 int_o after reset", int'(int_o), 0);
    chk("R1 vec_o after reset", int'(vec_o), 0);
    rst_ni = 1'b1;
    tick();
    pulse(16'h0001);
    chk("R1 masked after reset", int'(int_o), 0);

    wr(3'd1, 8'h20);
    wr(3'd5, 8'h70);
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h00);
    chk("R12 unmask shows latched line 0", int'(int_o), 1);
    ack();
    chk("R5 vector line 0", int'(vec_o), 'h20);
    wr(3'd3, 8'h00);

    // fixed priority and in-service blocking
    pulse(16'h0028);
    ack();
    chk("R4 line 3 beats 5", int'(vec_o), 'h23);
    chk("R4 in-service blocks line 5", int'(int_o), 0);
    wr(3'd3, 8'h00);
    chk("R10 eoi releases line 5", int'(int_o), 1);
    ack();
    chk("R5 vector line 5", int'(vec_o), 'h25);
    repeat (2) tick();
    chk("R5 vector held", int'(vec_o), 'h25);
    wr(3'd3, 8'h00);

    // rotated priority
    wr(3'd2, 8'h04);
    pulse(16'h0042);
    ack();
    chk("R4 rotated line 6 beats 1", int'(vec_o), 'h26);
    wr(3'd3, 8'h00);
    ack();
    chk("R4 rotated then line 1", int'(vec_o), 'h21);
    wr(3'd3, 8'h00);
    wr(3'd2, 8'h00);

    // held level
    irq_i = 16'h0010;
    tick();
    ack();
    chk("R2 held line 4 vector", int'(vec_o), 'h24);
    wr(3'd3, 8'h00);
    repeat (3) tick();
    chk("R2 held level no new request", int'(int_o), 0);
    irq_i = '0;
    tick();

    // cascade
    pulse(16'h0800);
    tick();
    chk("R6 slave reaches master", int'(int_o), 1);
    ack();
    chk("R6 slave vector", int'(vec_o), 'h73);
    wr(3'd7, 8'h00);
    wr(3'd3, 8'h00);
    chk("R6 idle after both eoi", int'(int_o), 0);

    ack();
    chk("R7 master spurious vector", int'(vec_o), 'h27);
    chk("R7 no state change", int'(int_o), 0);

    // slave spurious
    pulse(16'h0800);
    tick();
    wr(3'd4, 8'h08);
    ack();
    chk("R8 slave spurious vector", int'(vec_o), 'h77);
    wr(3'd3, 8'h00);
    chk("R8 idle while slave masked", int'(int_o), 0);
    wr(3'd4, 8'h00);
    tick();
    chk("R8 slave request kept", int'(int_o), 1);
    ack();
    chk("R8 kept slave line vector", int'(vec_o), 'h73);
    wr(3'd7, 8'h00);
    wr(3'd3, 8'h00);

    // stale line 2 with lower line pending
    pulse(16'h0840);
    tick();
    wr(3'd4, 8'h08);
    tick();
    chk("R9 lower line still requests", int'(int_o), 1);
    ack();
    chk("R9 lower line delivered", int'(vec_o), 'h26);
    wr(3'd3, 8'h00);
    wr(3'd4, 8'h00);
    tick();
    ack();
    chk("R9 slave after unmask", int'(vec_o), 'h73);
    wr(3'd7, 8'h00);
    wr(3'd3, 8'h00);

    // stale line 2 alone
    pulse(16'h0800);
    tick();
    wr(3'd4, 8'h08);
    tick();
    chk("R9 stale line 2 dropped", int'(int_o), 0);
    wr(3'd4, 8'h00);
    tick();
    ack();
    chk("R9 slave vector after stale", int'(vec_o), 'h73);
    wr(3'd7, 8'h00);
    wr(3'd3, 8'h00);

    pulse(16'h0004);
    tick();
    chk("R11 irq_i[2] ignored", int'(int_o), 0);

    // eoi addressing and nesting
    pulse(16'h0020);
    ack();
    pulse(16'h0002);
    ack();
    chk("R10 nested line 1", int'(vec_o), 'h21);
    wr(3'd7, 8'h00);
    pulse(16'h0040);
    chk("R10 slave eoi leaves master", int'(int_o), 0);
    wr(3'd3, 8'h00);
    chk("R10 line 5 still in service", int'(int_o), 0);
    wr(3'd3, 8'h00);
    chk("R10 second eoi frees line 6", int'(int_o), 1);
    ack();
    chk("R10 line 6 vector", int'(vec_o), 'h26);
    wr(3'd3, 8'h00);
    tick();
    finish_run();
  end
endmodule